// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interface of a 16-bit NOR-style non-volatile memory. It watches bus write cycles (address, data, chip enable, write enable) and recognises the multi-write unlock sequences that request a word program or a whole-array erase. Any write that does not fit the expected sequence sends it back to plain array reads.

Once a sequence completes, the block runs an embedded operation for a parameterised number of clock cycles. It raises a busy level toward a simple array model and gives a one-cycle done pulse when the array must commit the change. While the operation runs, reads return status bits instead of array data: a polling bit, a toggling bit and a timeout flag. An active-low reset input aborts everything. An accelerate input lets programming start without the two unlock writes. A test input forces the timeout condition.

Top module: `nvm_cmd_seq`

## Requirements
- R1: A program command is the writes AAh@555h, 55h@2AAh and A0h@555h, then one write carrying the target address and data. It produces exactly one array program of that address and data (`arr_op`=0). Only address bits [10:0] and data bits [7:0] are compared in unlock writes.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produce one whole-array erase (`arr_op`=1).
- R3: Inside a sequence, a write with the wrong address or the wrong data, or a write out of order, returns the decoder to array reads. The rest of the sequence then starts no operation.
- R4: A write of F0h during a partial sequence returns the decoder to array reads.
- R5: A write cycle with chip enable high is ignored. It neither advances nor breaks a sequence. A write is taken when the combined strobe (chip enable low and write enable low) ends.
- R6: `arr_busy` stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. `arr_done` pulses in the last busy cycle. Reads then return array data with no further command.
- R7: During an operation, reads return status: bit 7 is the inverse of bit 7 of the programmed data (0 for an erase). Bit 5 is the timeout flag. All bits other than 7, 6 and 5 read 0.
- R8: During an operation, status bit 6 changes after every completed read cycle (chip enable and output enable both low, then released). It starts at 0. Once array reads resume it no longer toggles.
- R9: `tst_force_tmo` high during an operation aborts it without `arr_done` and sets status bit 5. The status stays on the outputs until a write of F0h, after which array data is read.
- R10: `rst_n` low ends any operation or partial sequence without `arr_done` and returns to array reads.
- R11: With `accel_en` high, the single write A0h@555h followed by the address/data write starts a program. With `accel_en` low the same two writes do nothing.
- R12: Writes during a running operation are ignored: the latched address and data stay unchanged and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, aborts operations |
| bus_addr | input | AW | Bus address |
| bus_din | input | DW | Bus write data |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| accel_en | input | 1 | Skip unlock writes for programming |
| tst_force_tmo | input | 1 | Test: force operation timeout |
| arr_rdata | input | DW | Array read data at bus_addr |
| bus_dout | output | DW | Array data or status word |
| arr_busy | output | 1 | Embedded operation running |
| arr_done | output | 1 | One-cycle commit pulse to the array |
| arr_op | output | 1 | 0 program, 1 erase |
| arr_addr | output | AW | Latched program address |
| arr_wdata | output | DW | Latched program data |

## Verification
The bench corrupts the address or data of every unlock position of both sequences. A decoder that checked only data, only address, or only some cycles would start an operation, and the bench detects that through the busy count and the array contents. It counts busy cycles exactly, so an off-by-one timer shows up. It reads status words back to back, which exposes a toggle bit that fails to flip, or keeps flipping after the operation ends. Further cases catch a decoder that commits after a forced timeout or a reset, that treats chip-enable-high writes as breaking the sequence, or that lets a write during busy overwrite the latched word.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
   typedef enum logic [3:0] {
      SQ_READ, SQ_UL1, SQ_UL2, SQ_PGM_WAIT,
      SQ_ER3, SQ_ER4, SQ_ER5, SQ_BUSY, SQ_FAIL
   } seq_state_e;

   typedef enum logic {OP_PGM = 1'b0, OP_ERASE = 1'b1} op_kind_e;

   localparam int CMD_AW = 11;
   localparam logic [7:0] KEY_A    = 8'hAA;
   localparam logic [7:0] KEY_B    = 8'h55;
   localparam logic [7:0] KEY_PGM  = 8'hA0;
   localparam logic [7:0] KEY_ERS  = 8'h80;
   localparam logic [7:0] KEY_CHIP = 8'h10;
   localparam logic [7:0] KEY_RST  = 8'hF0;
   localparam logic [CMD_AW-1:0] ADR_A = 11'h555;
   localparam logic [CMD_AW-1:0] ADR_B = 11'h2AA;
endpackage

// File: rtl/nvm_strobe_edge.sv
module nvm_strobe_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] act,
   output logic [N-1:0] end_evt
);
   for (genvar i = 0; i < N; i++) begin : g_edge
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= act[i];
      end
      assign end_evt[i] = act_q & ~act[i];
   end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer
   import nvm_cmd_pkg::*;
#(
   parameter int PROG_CYCLES  = 1000,
   parameter int ERASE_CYCLES = 4000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     run,
   input  op_kind_e kind,
   output logic     last
);
   localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CW   = $clog2(MAXC);
   localparam logic [CW-1:0] P_LAST = CW'(PROG_CYCLES - 1);
   localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (start) cnt <= '0;
      else if (run)   cnt <= cnt + CW'(1);
   end

   assign last = run && (cnt == ((kind == OP_ERASE) ? E_LAST : P_LAST));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= CW'(MAXC - 1))); // R6
endmodule

// File: rtl/nvm_cmd_fsm.sv
module nvm_cmd_fsm
   import nvm_cmd_pkg::*;
#(
   parameter int AW     = 22,
   parameter int DW     = 16,
   parameter bit ACC_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_evt,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic          accel,
   input  logic          tmo,
   input  logic          tmr_last,
   output seq_state_e    st,
   output logic          op_start,
   output logic          op_commit,
   output op_kind_e      op_kind,
   output logic [AW-1:0] lat_addr,
   output logic [DW-1:0] lat_data
);
   seq_state_e nxt;
   op_kind_e   nxt_kind;
   logic       accel_eff;

   if (ACC_EN) begin : g_acc
      assign accel_eff = accel;
   end else begin : g_noacc
      logic unused_acc;
      assign unused_acc = accel;
      assign accel_eff  = 1'b0;
   end

   logic a_hit, b_hit;
   logic [7:0] key;
   assign a_hit = (addr[CMD_AW-1:0] == ADR_A);
   assign b_hit = (addr[CMD_AW-1:0] == ADR_B);
   assign key   = din[7:0];

   always_comb begin
      nxt      = st;
      nxt_kind = op_kind;
      op_start = 1'b0;
      unique case (st)
         SQ_READ: if (wr_evt) begin
            if (accel_eff && a_hit && key == KEY_PGM) nxt = SQ_PGM_WAIT;
            else if (a_hit && key == KEY_A)           nxt = SQ_UL1;
         end
         SQ_UL1: if (wr_evt) nxt = (b_hit && key == KEY_B) ? SQ_UL2 : SQ_READ;
         SQ_UL2: if (wr_evt) begin
            if (a_hit && key == KEY_PGM)      nxt = SQ_PGM_WAIT;
            else if (a_hit && key == KEY_ERS) nxt = SQ_ER3;
            else                              nxt = SQ_READ;
         end
         SQ_PGM_WAIT: if (wr_evt) begin
            nxt = SQ_BUSY; nxt_kind = OP_PGM; op_start = 1'b1;
         end
         SQ_ER3: if (wr_evt) nxt = (a_hit && key == KEY_A) ? SQ_ER4 : SQ_READ;
         SQ_ER4: if (wr_evt) nxt = (b_hit && key == KEY_B) ? SQ_ER5 : SQ_READ;
         SQ_ER5: if (wr_evt) begin
            if (a_hit && key == KEY_CHIP) begin
               nxt = SQ_BUSY; nxt_kind = OP_ERASE; op_start = 1'b1;
            end else nxt = SQ_READ;
         end
         SQ_BUSY: begin
            if (tmo)           nxt = SQ_FAIL;
            else if (tmr_last) nxt = SQ_READ;
         end
         SQ_FAIL: if (wr_evt && key == KEY_RST) nxt = SQ_READ;
         default: nxt = SQ_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_READ;
         op_kind  <= OP_PGM;
         lat_addr <= '0;
         lat_data <= '0;
      end else begin
         st      <= nxt;
         op_kind <= nxt_kind;
         if (op_start) begin
            lat_addr <= addr;
            lat_data <= din;
         end
      end
   end

   assign op_commit = (st == SQ_BUSY) && tmr_last && !tmo;

   AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == SQ_BUSY) |-> $past(wr_evt)); // R1
   AST_BUSY_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_BUSY && wr_evt) |=> ($stable(lat_addr) && $stable(lat_data))); // R12
   AST_COMMIT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      op_commit |=> (st == SQ_READ)); // R6
   AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_FAIL && !(wr_evt && key == KEY_RST)) |=> (st == SQ_FAIL)); // R9
endmodule

// File: rtl/nvm_status_out.sv
module nvm_status_out
   import nvm_cmd_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_evt,
   input  logic          show,
   input  logic          fail,
   input  op_kind_e      kind,
   input  logic          data_b7,
   input  logic [DW-1:0] arr_rdata,
   output logic [DW-1:0] dout
);
   logic          tog;
   logic [DW-1:0] status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tog <= 1'b0;
      else if (!show)  tog <= 1'b0;
      else if (rd_evt) tog <= ~tog;
   end

   always_comb begin
      status    = '0;
      status[7] = (kind == OP_PGM) ? ~data_b7 : 1'b0;
      status[6] = tog;
      status[5] = fail;
   end

   assign dout = show ? status : arr_rdata;

   AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (show && $past(show) && $past(rd_evt)) |-> (dout[6] != $past(dout[6]))); // R8
   AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (show && $past(show) && !$past(rd_evt)) |-> $stable(dout[6])); // R8
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
   import nvm_cmd_pkg::*;
#(
   parameter int AW           = 22,
   parameter int DW           = 16,
   parameter int PROG_CYCLES  = 1000,
   parameter int ERASE_CYCLES = 4000,
   parameter bit ACC_EN       = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_din,
   input  logic          bus_ce_n,
   input  logic          bus_we_n,
   input  logic          bus_oe_n,
   input  logic          accel_en,
   input  logic          tst_force_tmo,
   input  logic [DW-1:0] arr_rdata,
   output logic [DW-1:0] bus_dout,
   output logic          arr_busy,
   output logic          arr_done,
   output logic          arr_op,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] arr_wdata
);
   if (AW < CMD_AW) begin : g_bad_aw
      $error("AW must cover the unlock address bits");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must hold a command byte");
   end
   if (PROG_CYCLES < 2 || ERASE_CYCLES < 2) begin : g_bad_len
      $error("operation lengths must be at least 2 cycles");
   end

   localparam int WR = 0;
   localparam int RD = 1;

   logic [1:0] act, evt;
   assign act[WR] = ~bus_ce_n & ~bus_we_n;
   assign act[RD] = ~bus_ce_n & ~bus_oe_n;

   nvm_strobe_edge #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .act(act), .end_evt(evt)
   );

   seq_state_e st;
   op_kind_e   kind;
   logic       start, commit, last;

   nvm_cmd_fsm #(.AW(AW), .DW(DW), .ACC_EN(ACC_EN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_evt(evt[WR]), .addr(bus_addr), .din(bus_din),
      .accel(accel_en), .tmo(tst_force_tmo), .tmr_last(last), .st(st),
      .op_start(start), .op_commit(commit), .op_kind(kind),
      .lat_addr(arr_addr), .lat_data(arr_wdata)
   );

   nvm_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(start), .run(st == SQ_BUSY),
      .kind(kind), .last(last)
   );

   nvm_status_out #(.DW(DW)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd_evt(evt[RD]),
      .show(st == SQ_BUSY || st == SQ_FAIL), .fail(st == SQ_FAIL),
      .kind(kind), .data_b7(arr_wdata[7]), .arr_rdata(arr_rdata), .dout(bus_dout)
   );

   assign arr_busy = (st == SQ_BUSY);
   assign arr_done = commit;
   assign arr_op   = (kind == OP_ERASE);

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_done |=> !arr_busy); // R6
   AST_NO_DONE_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_busy && tst_force_tmo) |-> !arr_done); // R9
endmodule

// File: tb/tb_nvm_cmd_seq.sv
`timescale 1ns/1ps
module tb_nvm_cmd_seq;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int PL = 24;
   localparam int EL = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_din = '0;
   logic bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
   logic accel_en = 1'b0, tst_force_tmo = 1'b0;
   logic [DW-1:0] arr_rdata, bus_dout, arr_wdata;
   logic arr_busy, arr_done, arr_op;
   logic [AW-1:0] arr_addr;

   always #2 clk = ~clk;

   nvm_cmd_seq #(.AW(AW), .DW(DW), .PROG_CYCLES(PL), .ERASE_CYCLES(EL)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
      .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
      .accel_en(accel_en), .tst_force_tmo(tst_force_tmo), .arr_rdata(arr_rdata),
      .bus_dout(bus_dout), .arr_busy(arr_busy), .arr_done(arr_done), .arr_op(arr_op),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata)
   );

   // array model
   logic [DW-1:0] mem [1<<AW];
   assign arr_rdata = mem[bus_addr];
   int busy_cnt = 0, done_cnt = 0;
   always @(posedge clk) begin
      if (arr_busy) busy_cnt <= busy_cnt + 1;
      if (arr_done) begin
         done_cnt <= done_cnt + 1;
         if (arr_op) for (int i = 0; i < (1<<AW); i++) mem[i] <= 16'hFFFF;
         else mem[arr_addr] <= mem[arr_addr] & arr_wdata;
      end
   end

   function automatic logic [15:0] f(int a);
      return 16'((a * 40503) ^ 'h3C5A);
   endfunction

   int n_chk = 0, n_fail = 0;
   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk); bus_addr = a; bus_din = d; bus_ce_n = 0; bus_we_n = 0;
      @(negedge clk); bus_we_n = 1; bus_ce_n = 1;
   endtask
   task automatic wr_noce(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk); bus_addr = a; bus_din = d; bus_ce_n = 1; bus_we_n = 0;
      @(negedge clk); bus_we_n = 1;
   endtask
   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk); bus_addr = a; bus_ce_n = 0; bus_oe_n = 0;
      #1 v = bus_dout;
      @(negedge clk); bus_ce_n = 1; bus_oe_n = 1;
   endtask
   task automatic prog(logic [AW-1:0] a, logic [DW-1:0] d);
      wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(a, d);
   endtask
   task automatic erase();
      wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h80);
      wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h10);
   endtask
   task automatic wait_idle(output int n);
      n = 0;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (arr_busy) n++;
         else if (n > 0) break;
      end
   endtask
   task automatic idle(int c);
      repeat (c) @(negedge clk);
   endtask

   logic [11:0] pa [4] = '{12'h555, 12'h2AA, 12'h555, 12'h300};
   logic [15:0] pd [4] = '{16'hAA, 16'h55, 16'hA0, 16'h1234};
   logic [11:0] ea [6] = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
   logic [15:0] ed [6] = '{16'hAA, 16'h55, 16'h80, 16'hAA, 16'h55, 16'h10};

   initial begin
      logic [15:0] v;
      int n, b0, d0;
      for (int i = 0; i < (1<<AW); i++) mem[i] = f(i);
      idle(3); rst_n = 1; idle(1);
      // reset state (R10)
      chk("R10 reset busy", arr_busy, 0);
      chk("R10 reset done", arr_done, 0);
      rd(12'h010, v); chk("R10 reset read", v, f('h010));

      // program + exact length (R1, R6)
      prog(12'h123, 16'h5A3C); wait_idle(n);
      chk("R6 program busy length", n, PL);
      rd(12'h123, v); chk("R1 program result", v, f('h123) & 16'h5A3C);
      for (int i = 0; i < 8; i++) begin
         logic [11:0] a = 12'((i * 311 + 17) & 12'hFFF) | 12'h800;
         logic [15:0] d = 16'((i * 8191) ^ 16'hC3A5);
         prog(a, d); wait_idle(n);
         rd(a, v); chk("R1 program sweep", v, f(a) & d);
      end

      // status, bit7 = 1 in data (R7, R8)
      prog(12'h040, 16'h80F1);
      rd(12'h040, v); chk("R7 status b7 inverted, first", v, 16'h0000);
      rd(12'h040, v); chk("R8 toggle second", v, 16'h0040);
      rd(12'h040, v); chk("R8 toggle third", v, 16'h0000);
      wait_idle(n);
      rd(12'h040, v); chk("R8 array after op", v, f('h040) & 16'h80F1);
      rd(12'h040, v); chk("R8 no toggle after op", v, f('h040) & 16'h80F1);
      prog(12'h041, 16'h1234);
      rd(12'h041, v); chk("R7 status b7=1", v, 16'h0080);
      rd(12'h041, v); chk("R8 toggle b7=1", v, 16'h00C0);
      wait_idle(n);

      // mismatch sweep (R3)
      for (int p = 0; p < 3; p++) for (int k = 0; k < 2; k++) begin
         b0 = busy_cnt;
         for (int i = 0; i < 4; i++)
            if (i == p) wr(k ? pa[i] : pa[i] ^ 12'h001, k ? pd[i] ^ 16'h0001 : pd[i]);
            else wr(pa[i], pd[i]);
         idle(3);
         chk("R3 program mismatch no op", busy_cnt - b0, 0);
         rd(12'h300, v); chk("R3 program mismatch array", v, f('h300));
      end
      for (int p = 0; p < 6; p++) for (int k = 0; k < 2; k++) begin
         b0 = busy_cnt;
         for (int i = 0; i < 6; i++)
            if (i == p) wr(k ? ea[i] : ea[i] ^ 12'h001, k ? ed[i] ^ 16'h0001 : ed[i]);
            else wr(ea[i], ed[i]);
         idle(3);
         chk("R3 erase mismatch no op", busy_cnt - b0, 0);
         rd(12'h301, v); chk("R3 erase mismatch array", v, f('h301));
      end
      b0 = busy_cnt;
      wr(12'h2AA, 16'h55); wr(12'h555, 16'hAA); wr(12'h555, 16'hA0); wr(12'h302, 16'h0);
      idle(3); chk("R3 out of order no op", busy_cnt - b0, 0);

      // F0 mid-sequence (R4)
      b0 = busy_cnt;
      wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h000, 16'hF0);
      wr(12'h555, 16'hA0); wr(12'h303, 16'h0000);
      wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h80); wr(12'h7FF, 16'hF0);
      wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h10);
      idle(3); chk("R4 F0 aborts sequences", busy_cnt - b0, 0);
      rd(12'h303, v); chk("R4 array unchanged", v, f('h303));

      // chip enable high (R5)
      b0 = busy_cnt;
      wr_noce(12'h555, 16'hAA); wr_noce(12'h2AA, 16'h55); wr_noce(12'h555, 16'hA0);
      wr_noce(12'h304, 16'h0000); idle(3);
      chk("R5 ce high ignored", busy_cnt - b0, 0);
      wr(12'h555, 16'hAA); wr_noce(12'h000, 16'h0000); wr(12'h2AA, 16'h55);
      wr_noce(12'h123, 16'hF0); wr(12'h555, 16'hA0); wr(12'h305, 16'h00F0);
      wait_idle(n);
      rd(12'h305, v); chk("R5 ce high does not break sequence", v, f('h305) & 16'h00F0);

      // timeout (R9)
      d0 = done_cnt;
      prog(12'h306, 16'h00FF); idle(2);
      tst_force_tmo = 1; idle(1); tst_force_tmo = 0;
      rd(12'h306, v); chk("R9 status b5", v, 16'h0020);
      rd(12'h306, v); chk("R9 status toggles in fail", v, 16'h0060);
      idle(PL + 10);
      chk("R9 no commit", done_cnt - d0, 0);
      rd(12'h306, v); chk("R9 status persists", v, 16'h0020);
      wr(12'h000, 16'hF0);
      rd(12'h306, v); chk("R9 F0 restores array", v, f('h306));

      // reset (R10)
      d0 = done_cnt;
      prog(12'h310, 16'h0000); idle(5);
      rst_n = 0; idle(2); rst_n = 1; idle(1);
      chk("R10 busy cleared", arr_busy, 0);
      chk("R10 no commit", done_cnt - d0, 0);
      rd(12'h310, v); chk("R10 array unchanged", v, f('h310));
      b0 = busy_cnt;
      wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55);
      rst_n = 0; idle(1); rst_n = 1;
      wr(12'h555, 16'hA0); wr(12'h311, 16'h0000); idle(3);
      chk("R10 reset clears partial", busy_cnt - b0, 0);

      // accelerate (R11)
      accel_en = 1;
      wr(12'h555, 16'hA0); wr(12'h312, 16'h5555); wait_idle(n);
      chk("R11 accel busy length", n, PL);
      rd(12'h312, v); chk("R11 accel program", v, f('h312) & 16'h5555);
      accel_en = 0; b0 = busy_cnt;
      wr(12'h555, 16'hA0); wr(12'h313, 16'h0000); idle(3);
      chk("R11 no accel no op", busy_cnt - b0, 0);

      // writes during busy (R12)
      b0 = busy_cnt;
      prog(12'h314, 16'h0F0F);
      wr(12'h315, 16'h0000); wr(12'h555, 16'hAA); wr(12'h314, 16'h0000);
      wait_idle(n); idle(3);
      chk("R12 single op", busy_cnt - b0, PL);
      rd(12'h314, v); chk("R12 latched data kept", v, f('h314) & 16'h0F0F);
      rd(12'h315, v); chk("R12 other addr untouched", v, f('h315));

      // erase (R2, R6, R7)
      erase(); wait_idle(n);
      chk("R6 erase busy length", n, EL);
      rd(12'h000, v); chk("R2 erased low", v, 16'hFFFF);
      rd(12'hABC, v); chk("R2 erased mid", v, 16'hFFFF);
      prog(12'h777, 16'h1357); wait_idle(n);
      erase();
      rd(12'h777, v); chk("R7 erase status first", v, 16'h0000);
      rd(12'h777, v); chk("R8 erase status toggles", v, 16'h0040);
      wait_idle(n);
      rd(12'h777, v); chk("R2 erase after program", v, 16'hFFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule